// File: doc/BRIEF.md
# USB Endpoint Control and Handshake Register Bank

This block holds the firmware-facing control byte for several USB function endpoints (three by default). Each endpoint sits at its own address on a shared byte-wide register port. Firmware uses the byte for three things. It marks that a packet has been loaded for transmission. It forces the endpoint to stall. It flags the final packet of a transfer. Writing ones to the low acknowledge positions clears three per-endpoint status flags: transmit complete, OUT packet received and stall sent. The acknowledge positions are not stored.

The serial interface engine reports events on shared inputs: a decoded token with its endpoint index and direction, end of a sent data packet, a host ACK, a good OUT data packet, and transaction abort. A small per-endpoint state machine uses these to choose the handshake. When an endpoint finishes a transmission it clears its transmit-ready flag by hardware, sets transmit complete, and raises its interrupt line if that line is enabled. CRC, FIFOs and the packet data path lie outside the block.

Each endpoint's state machine has four states. In EP_IDLE it waits for a token. EP_TX_SEND means a data packet is on the wire. EP_TX_ACK means the endpoint waits for the host's ACK. EP_RX_DATA means the endpoint waits for the OUT data packet.

From EP_IDLE, a token can lead to one of four outcomes:
- A stall reply, which stays in EP_IDLE.
- A NAK reply, which stays in EP_IDLE.
- An IN token with data ready, which answers with data and moves to EP_TX_SEND.
- An OUT token with nothing pending, which moves to EP_RX_DATA.

From the other states:
- EP_TX_SEND moves on end of packet. An isochronous endpoint completes and returns to EP_IDLE. Any other endpoint moves to EP_TX_ACK.
- EP_TX_ACK completes on the host ACK and returns to EP_IDLE.
- EP_RX_DATA answers ACK on good data and returns to EP_IDLE.
- Abort returns every non-idle state to EP_IDLE.

Top module: `usb_ep_ctl_bank`

## Requirements
- R1: After reset every control bit, status flag, interrupt and handshake output is 0. Every endpoint address reads 0x00. A handshake other than ACK only appears in the cycle after a token.
- R2: The byte layout is as follows:
  - Bit 6 is the last-packet flag, bit 5 is force stall and bit 4 is transmit ready. These three bits are stored and read back.
  - Bits 7 and 2 always read 0.
  - The acknowledge bits 3, 1 and 0 always read 0.
- R3: With force stall set, an IN or OUT token is answered with STALL (hs_code 2), even when transmit ready is set. The same cycle sets that endpoint's stall-sent flag.
- R4: An IN token with force stall and transmit ready both clear is answered with NAK (hs_code 1).
- R5: On a non-isochronous endpoint, an IN token with transmit ready set is answered with data (hs_code 3). Transmit ready clears and transmit complete sets only after end of packet followed by host ACK. Abort leaves transmit ready set.
- R6: On an isochronous endpoint, transmit ready clears and transmit complete sets at end of packet, with no ACK awaited.
- R7: irq[i] is high exactly while endpoint i has transmit complete set and irq_en[i] is high.
- R8: A write with bit 0, bit 1 or bit 3 set clears transmit complete, OUT received or stall sent respectively. The write stores bits 6..4 as usual.
- R9: A hardware set of a status flag in the same cycle as its acknowledge write leaves the flag set.
- R10: An OUT token with no unacknowledged OUT packet gives no immediate handshake. A following good data packet is answered ACK (hs_code 0) and sets OUT received. An OUT token while OUT received is still set is answered NAK.
- R11: Endpoint i is written and read only at address EP_BASE+i (0x4, 0x5, 0x6 by default). Other addresses change nothing and read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of addressed endpoint |
| ep_iso | input | NUM_EP | Endpoint is isochronous |
| irq_en | input | NUM_EP | Transmit-complete interrupt enable |
| tok_valid | input | 1 | Token decoded this cycle |
| tok_ep | input | EP_IDX_W | Token endpoint index |
| tok_in | input | 1 | Token is IN (1) or OUT (0) |
| data_done | input | 1 | Data packet transmission finished |
| host_ack | input | 1 | Host ACK received |
| rx_good | input | 1 | OUT data packet received intact |
| txn_abort | input | 1 | Transaction abandoned |
| hs_valid | output | 1 | Handshake decision valid |
| hs_code | output | 2 | 0 ACK, 1 NAK, 2 STALL, 3 DATA |
| stat_tx_done | output | NUM_EP | Transmit complete flags |
| stat_rx_out | output | NUM_EP | OUT packet received flags |
| stat_stall_sent | output | NUM_EP | Stall sent flags |
| irq | output | NUM_EP | Interrupt requests |

## Verification
A table of writes and reads first tries the register path with all-ones, single-bit and reserved-only bytes, plus writes to unmapped and neighbouring addresses. This separates stored bits from bits that read as zero, and a correct decode from one that aliases. Directed token sequences then drive each handshake choice. Stall is issued against ready data. A NAK on an empty endpoint is set against the data reply. Non-isochronous completion with and without an ACK, and after an abort, is set against isochronous completion. A final case lands an OUT packet in the same cycle as its acknowledge write, to show that the set wins.

// File: rtl/usb_ep_pkg.sv
package usb_ep_pkg;
    typedef enum logic [1:0] {
        HS_ACK   = 2'd0,
        HS_NAK   = 2'd1,
        HS_STALL = 2'd2,
        HS_DATA  = 2'd3
    } hs_code_t;

    typedef enum logic [1:0] {
        EP_IDLE,
        EP_TX_SEND,
        EP_TX_ACK,
        EP_RX_DATA
    } ep_state_t;

    localparam int BIT_LAST   = 6;
    localparam int BIT_STALL  = 5;
    localparam int BIT_TXRDY  = 4;
    localparam int BIT_ACK_SS = 3;
    localparam int BIT_ACK_RX = 1;
    localparam int BIT_ACK_TX = 0;
endpackage

// File: rtl/usb_ep_regs.sv
module usb_ep_regs
    import usb_ep_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wdata,
    input  logic       hw_tx_clr,
    input  logic       set_tx_done,
    input  logic       set_rx_out,
    input  logic       set_stall,
    input  logic       irq_en,
    output logic       force_stall,
    output logic       tx_rdy,
    output logic       tx_done,
    output logic       rx_out,
    output logic       stall_sent,
    output logic       irq,
    output logic [7:0] rd_byte
);
    logic last_pkt;
    logic unused_bits;

    assign unused_bits = ^{wdata[7], wdata[2]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_pkt    <= 1'b0;
            force_stall <= 1'b0;
            tx_rdy      <= 1'b0;
            tx_done     <= 1'b0;
            rx_out      <= 1'b0;
            stall_sent  <= 1'b0;
        end else begin
            if (wr_en) begin
                last_pkt    <= wdata[BIT_LAST];
                force_stall <= wdata[BIT_STALL];
                tx_rdy      <= wdata[BIT_TXRDY];
            end else if (hw_tx_clr) begin
                tx_rdy <= 1'b0;
            end
            // hardware set dominates a same-cycle acknowledge
            tx_done    <= set_tx_done | (tx_done    & ~(wr_en & wdata[BIT_ACK_TX]));
            rx_out     <= set_rx_out  | (rx_out     & ~(wr_en & wdata[BIT_ACK_RX]));
            stall_sent <= set_stall   | (stall_sent & ~(wr_en & wdata[BIT_ACK_SS]));
        end
    end

    assign irq     = tx_done & irq_en;
    assign rd_byte = {1'b0, last_pkt, force_stall, tx_rdy, 4'b0000};
endmodule

// File: rtl/usb_ep_fsm.sv
module usb_ep_fsm
    import usb_ep_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tok_hit,
    input  logic       tok_in,
    input  logic       force_stall,
    input  logic       tx_rdy,
    input  logic       rx_pend,
    input  logic       iso,
    input  logic       data_done,
    input  logic       host_ack,
    input  logic       rx_good,
    input  logic       abort,
    output logic       hs_valid,
    output logic [1:0] hs_code,
    output logic       tx_clr,
    output logic       set_tx_done,
    output logic       set_rx_out,
    output logic       set_stall
);
    ep_state_t state_q, state_d;
    logic      hs_v_d;
    hs_code_t  hs_c_d, hs_c_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= EP_IDLE;
            hs_valid <= 1'b0;
            hs_c_q   <= HS_ACK;
        end else begin
            state_q  <= state_d;
            hs_valid <= hs_v_d;
            hs_c_q   <= hs_c_d;
        end
    end

    assign hs_code = hs_c_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EP_IDLE: begin
                if (tok_hit && !force_stall) begin
                    if (tok_in && tx_rdy)      state_d = EP_TX_SEND;
                    else if (!tok_in && !rx_pend) state_d = EP_RX_DATA;
                end
            end
            EP_TX_SEND: begin
                if (abort)          state_d = EP_IDLE;
                else if (data_done) state_d = iso ? EP_IDLE : EP_TX_ACK;
            end
            EP_TX_ACK: begin
                if (abort || host_ack) state_d = EP_IDLE;
            end
            EP_RX_DATA: begin
                if (abort || rx_good) state_d = EP_IDLE;
            end
            default: state_d = EP_IDLE;
        endcase
    end

    always_comb begin
        hs_v_d      = 1'b0;
        hs_c_d      = HS_ACK;
        tx_clr      = 1'b0;
        set_tx_done = 1'b0;
        set_rx_out  = 1'b0;
        set_stall   = 1'b0;
        unique case (state_q)
            EP_IDLE: begin
                if (tok_hit) begin
                    if (force_stall) begin
                        hs_v_d    = 1'b1;
                        hs_c_d    = HS_STALL;
                        set_stall = 1'b1;
                    end else if (tok_in) begin
                        hs_v_d = 1'b1;
                        hs_c_d = tx_rdy ? HS_DATA : HS_NAK;
                    end else if (rx_pend) begin
                        hs_v_d = 1'b1;
                        hs_c_d = HS_NAK;
                    end
                end
            end
            EP_TX_SEND: begin
                if (!abort && data_done && iso) begin
                    tx_clr      = 1'b1;
                    set_tx_done = 1'b1;
                end
            end
            EP_TX_ACK: begin
                if (!abort && host_ack) begin
                    tx_clr      = 1'b1;
                    set_tx_done = 1'b1;
                end
            end
            EP_RX_DATA: begin
                if (!abort && rx_good) begin
                    hs_v_d     = 1'b1;
                    hs_c_d     = HS_ACK;
                    set_rx_out = 1'b1;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/usb_ep_ctl_bank.sv
module usb_ep_ctl_bank #(
    parameter int NUM_EP   = 3,
    parameter int ADDR_W   = 4,
    parameter int EP_IDX_W = 2,
    parameter int EP_BASE  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [7:0]          reg_wdata,
    output logic [7:0]          reg_rdata,
    input  logic [NUM_EP-1:0]   ep_iso,
    input  logic [NUM_EP-1:0]   irq_en,
    input  logic                tok_valid,
    input  logic [EP_IDX_W-1:0] tok_ep,
    input  logic                tok_in,
    input  logic                data_done,
    input  logic                host_ack,
    input  logic                rx_good,
    input  logic                txn_abort,
    output logic                hs_valid,
    output logic [1:0]          hs_code,
    output logic [NUM_EP-1:0]   stat_tx_done,
    output logic [NUM_EP-1:0]   stat_rx_out,
    output logic [NUM_EP-1:0]   stat_stall_sent,
    output logic [NUM_EP-1:0]   irq
);
    logic [NUM_EP-1:0] sel, ep_hs_v, ep_stall, ep_txrdy;
    logic [NUM_EP-1:0] ep_txclr, ep_set_tx, ep_set_rx, ep_set_ss;
    logic [1:0]        ep_hs_c [NUM_EP];
    logic [7:0]        ep_byte [NUM_EP];

    for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
        assign sel[i] = (reg_addr == ADDR_W'(EP_BASE + i));

        usb_ep_regs u_regs (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr_en       (reg_wr & sel[i]),
            .wdata       (reg_wdata),
            .hw_tx_clr   (ep_txclr[i]),
            .set_tx_done (ep_set_tx[i]),
            .set_rx_out  (ep_set_rx[i]),
            .set_stall   (ep_set_ss[i]),
            .irq_en      (irq_en[i]),
            .force_stall (ep_stall[i]),
            .tx_rdy      (ep_txrdy[i]),
            .tx_done     (stat_tx_done[i]),
            .rx_out      (stat_rx_out[i]),
            .stall_sent  (stat_stall_sent[i]),
            .irq         (irq[i]),
            .rd_byte     (ep_byte[i])
        );

        usb_ep_fsm u_fsm (
            .clk         (clk),
            .rst_n       (rst_n),
            .tok_hit     (tok_valid && (tok_ep == EP_IDX_W'(i))),
            .tok_in      (tok_in),
            .force_stall (ep_stall[i]),
            .tx_rdy      (ep_txrdy[i]),
            .rx_pend     (stat_rx_out[i]),
            .iso         (ep_iso[i]),
            .data_done   (data_done),
            .host_ack    (host_ack),
            .rx_good     (rx_good),
            .abort       (txn_abort),
            .hs_valid    (ep_hs_v[i]),
            .hs_code     (ep_hs_c[i]),
            .tx_clr      (ep_txclr[i]),
            .set_tx_done (ep_set_tx[i]),
            .set_rx_out  (ep_set_rx[i]),
            .set_stall   (ep_set_ss[i])
        );
    end

    always_comb begin
        reg_rdata = 8'h00;
        hs_code   = 2'b00;
        for (int i = 0; i < NUM_EP; i++) begin
            if (sel[i])     reg_rdata = reg_rdata | ep_byte[i];
            if (ep_hs_v[i]) hs_code   = hs_code | ep_hs_c[i];
        end
    end

    assign hs_valid = |ep_hs_v;
endmodule

// File: rtl/usb_ep_ctl_chk.sv
module usb_ep_ctl_chk #(
    parameter int NUM_EP   = 3,
    parameter int EP_IDX_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [7:0]        reg_rdata,
    input logic [NUM_EP-1:0] irq_en,
    input logic              tok_valid,
    input logic              hs_valid,
    input logic [1:0]        hs_code,
    input logic [NUM_EP-1:0] stat_rx_out,
    input logic [NUM_EP-1:0] stat_stall_sent,
    input logic [NUM_EP-1:0] irq
);
    // R2
    rd_zero_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata & 8'h8F) == 8'h00);

    // R7
    irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq & ~irq_en) == '0);

    // R3
    stall_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_valid && hs_code == 2'd2) |-> (stat_stall_sent != '0));

    // R10
    out_ack_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_valid && hs_code == 2'd0) |-> (stat_rx_out != '0));

    // R1
    hs_after_token_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_valid && hs_code != 2'd0) |-> $past(tok_valid));
endmodule

bind usb_ep_ctl_bank usb_ep_ctl_chk #(.NUM_EP(NUM_EP), .EP_IDX_W(EP_IDX_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .reg_rdata       (reg_rdata),
    .irq_en          (irq_en),
    .tok_valid       (tok_valid),
    .hs_valid        (hs_valid),
    .hs_code         (hs_code),
    .stat_rx_out     (stat_rx_out),
    .stat_stall_sent (stat_stall_sent),
    .irq             (irq)
);

// File: tb/usb_ep_ctl_bank_tb.sv
module usb_ep_ctl_bank_tb;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [2:0] ep_iso = '0, irq_en = '0;
    logic       tok_valid = 1'b0, tok_in = 1'b0;
    logic [1:0] tok_ep = '0;
    logic       data_done = 1'b0, host_ack = 1'b0, rx_good = 1'b0, txn_abort = 1'b0;
    logic       hs_valid;
    logic [1:0] hs_code;
    logic [2:0] stat_tx_done, stat_rx_out, stat_stall_sent, irq;

    int checks = 0;
    int errors = 0;

    always #(CLK_P/2) clk = ~clk;

    usb_ep_ctl_bank u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ep_iso(ep_iso),
        .irq_en(irq_en), .tok_valid(tok_valid), .tok_ep(tok_ep), .tok_in(tok_in),
        .data_done(data_done), .host_ack(host_ack), .rx_good(rx_good),
        .txn_abort(txn_abort), .hs_valid(hs_valid), .hs_code(hs_code),
        .stat_tx_done(stat_tx_done), .stat_rx_out(stat_rx_out),
        .stat_stall_sent(stat_stall_sent), .irq(irq)
    );

    // {write addr, write data, read addr, expected read}
    localparam logic [31:0] VEC [0:8] = '{
        {8'h04, 8'hFF, 8'h04, 8'h70},   // R2 stored bits only
        {8'h05, 8'h10, 8'h05, 8'h10},   // R11 own address
        {8'h05, 8'h00, 8'h04, 8'h70},   // R11 neighbour untouched
        {8'h06, 8'h8F, 8'h06, 8'h00},   // R2 reserved and ack bits
        {8'h03, 8'hFF, 8'h03, 8'h00},   // R11 unmapped address
        {8'h07, 8'hFF, 8'h06, 8'h00},   // R11 unmapped write
        {8'h04, 8'h20, 8'h04, 8'h20},   // R2 force stall alone
        {8'h04, 8'h40, 8'h04, 8'h40},   // R2 last-packet alone
        {8'h04, 8'h00, 8'h04, 8'h00}    // R2 cleared
    };

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 4'(a); reg_wdata = 8'(d);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        reg_addr = 4'(a);
        #1;
        d = int'(reg_rdata);
    endtask

    task automatic token(input int ep, input bit is_in);
        @(negedge clk);
        tok_valid = 1'b1; tok_ep = 2'(ep); tok_in = is_in;
        @(negedge clk);
        tok_valid = 1'b0;
    endtask

    // 0 data_done, 1 host_ack, 2 rx_good, 3 abort
    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: data_done = 1'b1;
            1: host_ack  = 1'b1;
            2: rx_good   = 1'b1;
            default: txn_abort = 1'b1;
        endcase
        @(negedge clk);
        data_done = 1'b0; host_ack = 1'b0; rx_good = 1'b0; txn_abort = 1'b0;
    endtask

    initial begin
        #(CLK_P * 200000);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 4; a < 7; a++) begin
            rd(a, v);
            chk(v, 0, "R1 reset read");
        end
        chk(int'(hs_valid), 0, "R1 hs_valid");
        chk(int'({stat_tx_done, stat_rx_out, stat_stall_sent, irq}), 0, "R1 flags");

        for (int i = 0; i < 9; i++) begin
            wr(int'(VEC[i][31:24]), int'(VEC[i][23:16]));
            rd(int'(VEC[i][15:8]), v);
            chk(v, int'(VEC[i][7:0]), $sformatf("R2/R11 vector %0d", i));
        end

        // R4 NAK on empty IN
        token(0, 1'b1);
        chk(int'(hs_valid), 1, "R4 valid");
        chk(int'(hs_code), 1, "R4 NAK");

        // R3 stall beats data
        wr(4, 8'h30);
        token(0, 1'b1);
        chk(int'(hs_code), 2, "R3 stall on IN");
        chk(int'(stat_stall_sent[0]), 1, "R3 stall_sent");
        token(0, 1'b0);
        chk(int'(hs_valid), 1, "R3 valid on OUT");
        chk(int'(hs_code), 2, "R3 stall on OUT");

        // R8 stall-sent acknowledge
        wr(4, 8'h08);
        chk(int'(stat_stall_sent[0]), 0, "R8 stall ack");
        rd(4, v);
        chk(v, 0, "R8 control rewritten");

        // R5 non-iso completion
        irq_en = 3'b010;
        wr(5, 8'h10);
        token(1, 1'b1);
        chk(int'(hs_code), 3, "R5 data reply");
        pulse(0);
        chk(int'(hs_valid), 0, "R5 no handshake on send");
        rd(5, v);
        chk(v, 8'h10, "R5 ready held until ACK");
        chk(int'(stat_tx_done[1]), 0, "R5 not complete before ACK");
        pulse(1);
        rd(5, v);
        chk(v, 0, "R5 ready cleared by ACK");
        chk(int'(stat_tx_done[1]), 1, "R5 complete");
        chk(int'(irq[1]), 1, "R7 irq raised");
        irq_en = 3'b000;
        #1;
        chk(int'(irq[1]), 0, "R7 irq masked");
        wr(5, 8'h01);
        chk(int'(stat_tx_done[1]), 0, "R8 tx complete ack");

        // R5 abort keeps ready
        wr(5, 8'h10);
        token(1, 1'b1);
        pulse(0);
        pulse(3);
        rd(5, v);
        chk(v, 8'h10, "R5 abort keeps ready");
        pulse(1);
        rd(5, v);
        chk(v, 8'h10, "R5 stray ACK ignored");
        chk(int'(stat_tx_done[1]), 0, "R5 no completion after abort");
        wr(5, 8'h00);

        // R6 isochronous
        ep_iso = 3'b100;
        wr(6, 8'h50);
        token(2, 1'b1);
        chk(int'(hs_code), 3, "R6 data reply");
        pulse(0);
        rd(6, v);
        chk(v, 8'h40, "R6 ready cleared at send");
        chk(int'(stat_tx_done[2]), 1, "R6 complete without ACK");

        // R10 OUT path
        token(0, 1'b0);
        chk(int'(hs_valid), 0, "R10 no immediate handshake");
        pulse(2);
        chk(int'(hs_valid), 1, "R10 valid");
        chk(int'(hs_code), 0, "R10 ACK");
        chk(int'(stat_rx_out[0]), 1, "R10 rx_out set");
        token(0, 1'b0);
        chk(int'(hs_code), 1, "R10 NAK while pending");
        wr(4, 8'h02);
        chk(int'(stat_rx_out[0]), 0, "R8 rx ack");

        // R9 set beats acknowledge
        token(0, 1'b0);
        @(negedge clk);
        rx_good = 1'b1; reg_wr = 1'b1; reg_addr = 4'h4; reg_wdata = 8'h02;
        @(negedge clk);
        rx_good = 1'b0; reg_wr = 1'b0;
        chk(int'(stat_rx_out[0]), 1, "R9 set wins");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule